// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an internal single-beat request port and an external asynchronous static RAM of 524,288 bytes (19 address bits, 8 data bits). Each accepted request becomes one strobe sequence on the RAM's active-low chip-enable, output-enable and write-enable pins. Every phase is held for a whole number of system clock cycles, so the RAM's minimum access time, write pulse width, data setup and output turn-off time are met. All phase lengths are compile-time parameters, each rounded up from the nanosecond figure.

Writes are controlled by the write-enable strobe. Chip-enable and write-enable fall together, with no address setup. Output-enable stays high for the whole write. The data driver turns on only after the RAM's output turn-off time has passed, and it turns off on the same edge that raises write-enable, with no hold. For a read, chip-enable and output-enable go low together. The byte on the data pins is captured on the edge that ends the access wait, and both strobes rise on that same edge. The shared data pins are presented as separate output, output-enable and input vectors, so that the pad ring can build the tristate. Every access ends with a one-cycle done pulse. A read returns its byte alongside that pulse.

Top module: `sram_ctrl`

## Requirements
- R1: In reset and on leaving it, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` and `done` are 0, and `req_ready` is 1.
- R2: `req_ready` is 1 only when the controller is idle, and the strobes are all high whenever it is 1. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and its address appears on `mem_addr` from the next cycle. `mem_addr` does not change while `mem_ce_n` stays low.
- R3: A read (`req_write`=0) holds `mem_ce_n` and `mem_oe_n` low together for exactly RD_ACC_CYC cycles (default 3), with `mem_we_n` high and `mem_dq_oe` 0 throughout.
- R4: The byte on `mem_dq_in` at the last clock edge of the read is presented on `rdata` in the cycle where `done` is 1. All strobes are already high in that cycle.
- R5: A write (`req_write`=1) holds `mem_ce_n` and `mem_we_n` low together for TURNOFF_CYC plus the drive length (see R9), which is 3 cycles with the defaults. `mem_oe_n` stays high for the whole write.
- R6: `mem_dq_oe` is 1 only while `mem_we_n` is low and `mem_oe_n` is high. It is 0 during the first TURNOFF_CYC cycles of the write-enable pulse (default 1).
- R7: While `mem_dq_oe` is 1, `mem_dq_out` is steady and equals the request's `req_wdata`. `mem_dq_oe` falls on the same edge where `mem_we_n` rises, and the RAM stores that byte at the address of the request.
- R8: `done` is a single-cycle pulse, one per accepted request. After a write, `req_ready` is still 0 in the `done` cycle, giving one idle clock before the next access.
- R9: The write-enable low time is at least WE_PULSE_CYC, and data is driven for at least DSETUP_CYC cycles before write-enable rises. The drive length is max(DSETUP_CYC, WE_PULSE_CYC − TURNOFF_CYC, 1), which is 2 cycles with the defaults.
- R10: A request presented while `req_ready` is 0 has no effect. `mem_addr` keeps the address of the access in progress, and no write is made to the ignored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request may be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid with done after a read |
| mem_addr | output | 19 | RAM address pins |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_dq_out | output | 8 | Data toward the RAM |
| mem_dq_oe | output | 1 | Pad driver enable for mem_dq_out |
| mem_dq_in | input | 8 | Data from the RAM pins |

## Verification
A phase counter that is off by one shows up on the strobe pins at once: the low time of chip-enable, output-enable or write-enable differs from its parameter in the first access. A stuck or skipped state shows up at the ports as a drive enable that overlaps output-enable, a missing or doubled done pulse, or a ready that comes back without the idle clock after a write. All of these appear within one access of about five cycles. Capture and address faults appear later, as a wrong byte on the read-back of an address, possibly many accesses after the bad write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WR_SETTLE,
    ST_WR_DRIVE,
    ST_WR_GAP
  } ctrl_state_t;

  // Cycles the data driver stays on before write enable rises.
  function automatic int unsigned drive_len(int unsigned we_pulse,
                                            int unsigned turnoff,
                                            int unsigned setup);
    int unsigned rest;
    int unsigned len;
    rest = (we_pulse > turnoff) ? (we_pulse - turnoff) : 1;
    len  = (setup > rest) ? setup : rest;
    return (len == 0) ? 1 : len;
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b,
                                       int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_wdata,
  input  logic [DW-1:0] wdata_in,
  input  logic          drive_on,
  input  logic          drive_off,
  input  logic          sample,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_out <= '0;
      dq_oe  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (cap_wdata) dq_out <= wdata_in;
      if (drive_on)       dq_oe <= 1'b1;
      else if (drive_off) dq_oe <= 1'b0;
      if (sample) rdata <= dq_in;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW           = 19,
  parameter int unsigned DW           = 8,
  parameter int unsigned RD_ACC_CYC   = 3,
  parameter int unsigned WE_PULSE_CYC = 3,
  parameter int unsigned TURNOFF_CYC  = 1,
  parameter int unsigned DSETUP_CYC   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int unsigned DRIVE_CYC = drive_len(WE_PULSE_CYC, TURNOFF_CYC, DSETUP_CYC);
  localparam int unsigned MAX_CYC   = max3(RD_ACC_CYC, TURNOFF_CYC, DRIVE_CYC);
  localparam int unsigned TW        = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] RD_LOAD = TW'(RD_ACC_CYC - 1);
  localparam logic [TW-1:0] TO_LOAD = TW'(TURNOFF_CYC - 1);
  localparam logic [TW-1:0] DR_LOAD = TW'(DRIVE_CYC - 1);

  ctrl_state_t state;
  logic        tmr_exp;
  logic        tmr_load;
  logic [TW-1:0] tmr_val;

  // Named internal events
  logic accept, rd_end, settle_end, wr_end;
  assign accept     = req_valid && (state == ST_IDLE);
  assign rd_end     = (state == ST_READ)      && tmr_exp;
  assign settle_end = (state == ST_WR_SETTLE) && tmr_exp;
  assign wr_end     = (state == ST_WR_DRIVE)  && tmr_exp;

  assign req_ready = (state == ST_IDLE);
  assign tmr_load  = accept || settle_end;
  assign tmr_val   = accept ? (req_write ? TO_LOAD : RD_LOAD) : DR_LOAD;

  sram_phase_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_exp)
  );

  sram_data_path #(.DW(DW)) u_data (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_wdata (accept && req_write),
    .wdata_in  (req_wdata),
    .drive_on  (settle_end),
    .drive_off (wr_end),
    .sample    (rd_end),
    .dq_in     (mem_dq_in),
    .dq_out    (mem_dq_out),
    .dq_oe     (mem_dq_oe),
    .rdata     (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      mem_addr <= '0;
      mem_ce_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          mem_addr <= req_addr;
          mem_ce_n <= 1'b0;
          if (req_write) begin
            mem_we_n <= 1'b0;
            state    <= ST_WR_SETTLE;
          end else begin
            mem_oe_n <= 1'b0;
            state    <= ST_READ;
          end
        end
        ST_READ: if (rd_end) begin
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          done     <= 1'b1;
          state    <= ST_IDLE;
        end
        ST_WR_SETTLE: if (settle_end) state <= ST_WR_DRIVE;
        ST_WR_DRIVE: if (wr_end) begin
          mem_ce_n <= 1'b1;
          mem_we_n <= 1'b1;
          done     <= 1'b1;
          state    <= ST_WR_GAP;
        end
        ST_WR_GAP: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned AW           = 19,
  parameter int unsigned WE_PULSE_CYC = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          done,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic [7:0]    mem_dq_out,
  input logic          mem_dq_oe,
  input logic          accept
);
  logic [7:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= (we_low_cnt == 8'hFF) ? we_low_cnt : we_low_cnt + 1'b1;
    else                we_low_cnt <= '0;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done));

  a_r2_ready_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n));

  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  a_r3_read_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  a_r4_done_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_ce_n && mem_oe_n && mem_we_n));

  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_we_n));

  a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_accept_starts: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !mem_ce_n);

  a_r9_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt >= 8'(WE_PULSE_CYC)));
endmodule

bind sram_ctrl sram_ctrl_chk #(.AW(AW), .WE_PULSE_CYC(WE_PULSE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .done       (done),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe),
  .accept     (accept)
);

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RD_N  = 3;  // R3
  localparam int WE_N  = 3;  // R5: turnoff 1 + drive 2
  localparam int DRV_N = 2;  // R9

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, done;
  logic [7:0]  rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  // RAM model
  logic [7:0] ram [int];
  logic [7:0] rd_val = 8'h00;
  logic [7:0] lat_data = 8'h00;
  logic [18:0] lat_addr = '0;
  logic       prev_we = 1'b1;

  function automatic logic [7:0] dflt(logic [18:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? rd_val : 8'hEE;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard
  bit         exp_wr[$];
  logic [7:0] exp_val[$];
  logic [7:0] model [int];

  int we_run = 0, rd_run = 0, oe_run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      rd_val = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : dflt(mem_addr);
      // write commit at write-enable rise
      if (!prev_we && mem_we_n) begin
        ram[int'(lat_addr)] = lat_data;
        chk(we_run == WE_N, "R5 we low length", we_run, WE_N);
        chk(oe_run == DRV_N, "R9 drive length", oe_run, DRV_N);
        chk(!mem_dq_oe, "R7 drive off with we rise", mem_dq_oe, 0);
        we_run = 0; oe_run = 0;
      end
      if (!mem_we_n) begin
        if (we_run < 1 && mem_dq_oe) chk(0, "R6 drive during turnoff", 1, 0);
        if (!mem_oe_n) chk(0, "R5 oe low in write", 0, 1);
        we_run++;
        if (mem_dq_oe) begin
          oe_run++;
          lat_data = mem_dq_out;
          lat_addr = mem_addr;
        end
      end
      if (mem_dq_oe && !mem_oe_n) chk(0, "R6 contention", 1, 0);
      if (!mem_ce_n && !mem_oe_n) begin
        rd_run++;
        if (mem_dq_oe) chk(0, "R3 drive during read", 1, 0);
      end else if (rd_run != 0) begin
        chk(rd_run == RD_N, "R3 read strobe length", rd_run, RD_N);
        rd_run = 0;
      end
      if (req_ready && !(mem_ce_n && mem_oe_n && mem_we_n))
        chk(0, "R2 ready while active", 0, 1);
      if (done) begin
        if (exp_wr.size() == 0) chk(0, "R8 unexpected done", 1, 0);
        else begin
          automatic bit w = exp_wr.pop_front();
          automatic logic [7:0] v = exp_val.pop_front();
          chk(mem_ce_n && mem_oe_n && mem_we_n, "R4 strobes high at done", 0, 1);
          if (w) chk(!req_ready, "R8 gap after write", req_ready, 0);
          else   chk(rdata == v, "R4 read data", rdata, v);
        end
      end
      prev_we = mem_we_n;
    end
  end

  task automatic do_req(bit wr, logic [18:0] a, logic [7:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    exp_wr.push_back(wr);
    if (wr) begin
      model[int'(a)] = d;
      exp_val.push_back(d);
    end else
      exp_val.push_back(model.exists(int'(a)) ? model[int'(a)] : dflt(a));
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_addr == a, "R2 address presented", mem_addr, a);
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done, "R1 reset strobes", 0, 1);
    chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && !done, "R1 after reset", 0, 1);

    do_req(1, 19'h00010, 8'hA5);
    do_req(1, 19'h7FFFF, 8'h3C);
    do_req(0, 19'h00010, 8'h00);
    do_req(0, 19'h7FFFF, 8'h00);
    do_req(0, 19'h12345, 8'h00);       // never written: default pattern
    do_req(1, 19'h00000, 8'hFF);
    do_req(1, 19'h00000, 8'h00);       // overwrite
    do_req(0, 19'h00000, 8'h00);
    do_req(0, 19'h00000, 8'h00);       // back-to-back reads

    // R10: request while busy is ignored
    do_req(1, 19'h00100, 8'h77);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00200; req_wdata = 8'h99;
    repeat (3) begin
      @(negedge clk);
      chk(mem_addr == 19'h00100, "R10 busy request ignored", mem_addr, 19'h00100);
    end
    req_valid = 1'b0;
    do_req(0, 19'h00200, 8'h00);
    do_req(0, 19'h00100, 8'h00);

    for (int i = 0; i < 6; i++) begin
      do_req(1, 19'(i * 19'h1111), 8'(i * 37 + 1));
      do_req(0, 19'(i * 19'h1111), 8'h00);
    end

    repeat (10) @(negedge clk);
    chk(exp_wr.size() == 0, "R8 all done pulses seen", exp_wr.size(), 0);
    finish_sim();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_sim();
  end
endmodule